// File: doc/BRIEF.md
# Product-Term Cluster Allocator

This block models one logic block of a complex programmable logic device, with no clock anywhere in it. A programmable AND plane forms 83 product terms from 36 signal inputs. Eighty of those terms are grouped five at a time into sixteen clusters, one cluster per macrocell. The other three are shared control terms for the clock, the initialization and the output enable.

An allocator then builds a sum-of-products for each of the sixteen macrocells. Each cluster can stay at home, move one or two slices up or down, or be parked. Each slice can hand its accumulated sum to the slice four positions higher. Chaining those hand-offs builds sums of up to eighty terms. A per-slice bypass path takes the home cluster straight to the output.

All configuration arrives as static input buses. A conflict flag marks settings that the allocator cannot honour.

Top module: `logic_alloc_block`

## Requirements
- R1: Product term t is the AND of the literals selected by its fuse pairs. `cfg_and[t*72+2*i]` set selects `in_sig[i]`. `cfg_and[t*72+2*i+1]` set selects `~in_sig[i]`. An input with neither fuse set is excluded, and a term with no fuse set at all is 1.
- R2: A term that has both fuses of any input set is always 0.
- R3: Cluster n consists of terms 5n to 5n+4. Terms 80, 81 and 82 appear only on `sh_clk`, `sh_init` and `sh_oe`, and never enter any macrocell sum.
- R4: The 3-bit field `cfg_dest[3n+2:3n]` steers cluster n. The codes are: 0 to slice n, 1 to n-1, 2 to n-2, 3 to n+1, 4 to n+2. A cluster adds only to the slice it is steered to, and adds 0 to its home slice when it is steered away.
- R5: Codes 5, 6 and 7 park the cluster. A parked cluster reaches no slice and does not raise `cfg_conflict`.
- R6: Slice indices do not wrap. A cluster steered below slice 0 or above slice 15 adds to no slice and raises `cfg_conflict`.
- R7: With `cfg_bypass[n]` set and `cfg_wide[n]` clear, `mc_sum[n]` is the OR of cluster n alone. Steered-in clusters and chained sums are ignored for that output.
- R8: With `cfg_wide[n]` set, the accumulated sum of slice n is passed to slice n+4 and `mc_sum[n]` is 0. A slice's accumulated sum is the OR of the clusters steered to it and, when `cfg_wide[n-4]` is set, the accumulated sum of slice n-4. Chaining slices 0, 4, 8 and 12 carries cluster terms to `mc_sum[12]`.
- R9: `cfg_wide` set on slices 12 to 15 discards that sum, with the output still 0, and raises `cfg_conflict`.
- R10: `cfg_bypass[n]` set while cluster n has a code other than 0 raises `cfg_conflict`.
- R11: Every output is a combinational function of the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_sig | input | 36 | Signal inputs to the AND plane |
| cfg_and | input | 5976 | AND fuses, 72 per term, a true/complement pair per input |
| cfg_dest | input | 48 | Steering code per cluster, 3 bits each |
| cfg_wide | input | 16 | Forward slice sum to slice n+4 |
| cfg_bypass | input | 16 | Select the home-cluster-only path per slice |
| mc_sum | output | 16 | Sum-of-products to each macrocell |
| sh_clk | output | 1 | Shared clock product term |
| sh_init | output | 1 | Shared initialization product term |
| sh_oe | output | 1 | Shared output-enable product term |
| cfg_conflict | output | 1 | Configuration cannot be honoured |

## Verification
The assertions watch several properties at all times:
- a term with a clashing fuse pair stays 0;
- a home-steered cluster always reaches its slice's local sum;
- a slice whose neighbouring clusters are all quiet has no local sum;
- forwarding slices output 0;
- bypassed slices show only their own cluster;
- edge steering and top-slice forwarding always raise the conflict flag.

Only the bench's scenarios can show the full routing result, because they compare every output against an independent model. That includes:
- sums that pass through several chained slices;
- parking that stays silent;
- the effect of bypass on steered-in terms.

// File: rtl/lalloc_pkg.sv
package lalloc_pkg;
  localparam int LA_IN   = 36;
  localparam int LA_MC   = 16;
  localparam int LA_CL   = 5;
  localparam int LA_SH   = 3;
  localparam int LA_STEP = 4;
  localparam int LA_DW   = 3;
  localparam int LA_PARK = 99;

  typedef enum logic [LA_DW-1:0] {
    DST_OWN = 3'd0,
    DST_DN1 = 3'd1,
    DST_DN2 = 3'd2,
    DST_UP1 = 3'd3,
    DST_UP2 = 3'd4
  } dest_e;

  // slice offset a steering code moves a cluster by; LA_PARK when parked
  function automatic int dest_shift(input logic [LA_DW-1:0] code);
    case (code)
      DST_OWN: return 0;
      DST_DN1: return -1;
      DST_DN2: return -2;
      DST_UP1: return 1;
      DST_UP2: return 2;
      default: return LA_PARK;
    endcase
  endfunction

  // true when a non-parked code sends cluster src outside 0..n_mc-1
  function automatic logic lands_outside(input int src, input logic [LA_DW-1:0] code,
                                         input int n_mc);
    int sh;
    sh = dest_shift(code);
    if (sh == LA_PARK) return 1'b0;
    return (src + sh < 0) || (src + sh >= n_mc);
  endfunction
endpackage

// File: rtl/la_and_plane.sv
module la_and_plane #(
  parameter int N_IN = lalloc_pkg::LA_IN,
  parameter int N_PT = lalloc_pkg::LA_MC * lalloc_pkg::LA_CL + lalloc_pkg::LA_SH
) (
  input  logic [N_IN-1:0]        sig,
  input  logic [N_PT*2*N_IN-1:0] fuse,
  output logic [N_PT-1:0]        pt
);
  localparam int FW = 2 * N_IN;

  // even fuse selects the true literal, odd fuse the complement
  function automatic logic eval_term(input logic [FW-1:0] f, input logic [N_IN-1:0] x);
    logic r;
    r = 1'b1;
    for (int i = 0; i < N_IN; i++) begin
      if (f[2*i] && !x[i])   r = 1'b0;
      if (f[2*i+1] && x[i])  r = 1'b0;
    end
    return r;
  endfunction

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign pt[t] = eval_term(fuse[t*FW +: FW], sig);
  end
endmodule

// File: rtl/la_cluster_route.sv
module la_cluster_route
  import lalloc_pkg::*;
#(
  parameter int N_MC  = LA_MC,
  parameter int CL_SZ = LA_CL
) (
  input  logic [N_MC*CL_SZ-1:0] pt_cl,
  input  logic [N_MC*LA_DW-1:0] dest,
  output logic [N_MC-1:0]       cl_or,
  output logic [N_MC-1:0]       local_sum,
  output logic                  route_err
);
  logic [N_MC-1:0] off_edge;

  for (genvar n = 0; n < N_MC; n++) begin : g_cl
    assign cl_or[n]    = |pt_cl[n*CL_SZ +: CL_SZ];
    assign off_edge[n] = lands_outside(n, dest[n*LA_DW +: LA_DW], N_MC);
  end

  // gather: each slice looks at the clusters within two positions
  for (genvar d = 0; d < N_MC; d++) begin : g_slice
    logic hit;
    always_comb begin
      int s;
      hit = 1'b0;
      for (int k = -2; k <= 2; k++) begin
        s = d + k;
        if (s >= 0 && s < N_MC) begin
          if (dest_shift(dest[s*LA_DW +: LA_DW]) == -k) hit = hit | cl_or[s];
        end
      end
    end
    assign local_sum[d] = hit;
  end

  assign route_err = |off_edge;
endmodule

// File: rtl/la_wide_chain.sv
module la_wide_chain #(
  parameter int N_MC = lalloc_pkg::LA_MC,
  parameter int STEP = lalloc_pkg::LA_STEP
) (
  input  logic [N_MC-1:0] local_sum,
  input  logic [N_MC-1:0] own_or,
  input  logic [N_MC-1:0] wide,
  input  logic [N_MC-1:0] bypass,
  output logic [N_MC-1:0] acc,
  output logic [N_MC-1:0] mc_out,
  output logic            chain_err
);
  for (genvar n = 0; n < N_MC; n++) begin : g_acc
    if (n >= STEP) begin : g_link
      assign acc[n] = local_sum[n] | (wide[n-STEP] & acc[n-STEP]);
    end else begin : g_head
      assign acc[n] = local_sum[n];
    end
    assign mc_out[n] = wide[n] ? 1'b0 : (bypass[n] ? own_or[n] : acc[n]);
  end

  // the top STEP slices have nowhere to forward to
  assign chain_err = |wide[N_MC-1 -: STEP];
endmodule

// File: rtl/logic_alloc_block.sv
module logic_alloc_block
  import lalloc_pkg::*;
#(
  parameter int N_IN  = LA_IN,
  parameter int N_MC  = LA_MC,
  parameter int CL_SZ = LA_CL
) (
  input  logic [N_IN-1:0]                        in_sig,
  input  logic [(N_MC*CL_SZ+LA_SH)*2*N_IN-1:0]   cfg_and,
  input  logic [N_MC*LA_DW-1:0]                  cfg_dest,
  input  logic [N_MC-1:0]                        cfg_wide,
  input  logic [N_MC-1:0]                        cfg_bypass,
  output logic [N_MC-1:0]                        mc_sum,
  output logic                                   sh_clk,
  output logic                                   sh_init,
  output logic                                   sh_oe,
  output logic                                   cfg_conflict
);
  localparam int N_CLT = N_MC * CL_SZ;
  localparam int N_PT  = N_CLT + LA_SH;

  logic [N_PT-1:0] pt_vec;
  logic [N_MC-1:0] cl_or;
  logic [N_MC-1:0] local_sum;
  logic [N_MC-1:0] acc_sum;
  logic [N_MC-1:0] byp_bad;
  logic            route_err;
  logic            chain_err;

  la_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_plane (
    .sig (in_sig),
    .fuse(cfg_and),
    .pt  (pt_vec)
  );

  la_cluster_route #(.N_MC(N_MC), .CL_SZ(CL_SZ)) u_route (
    .pt_cl    (pt_vec[N_CLT-1:0]),
    .dest     (cfg_dest),
    .cl_or    (cl_or),
    .local_sum(local_sum),
    .route_err(route_err)
  );

  la_wide_chain #(.N_MC(N_MC), .STEP(LA_STEP)) u_chain (
    .local_sum(local_sum),
    .own_or   (cl_or),
    .wide     (cfg_wide),
    .bypass   (cfg_bypass),
    .acc      (acc_sum),
    .mc_out   (mc_sum),
    .chain_err(chain_err)
  );

  for (genvar n = 0; n < N_MC; n++) begin : g_byp
    assign byp_bad[n] = cfg_bypass[n] & (cfg_dest[n*LA_DW +: LA_DW] != DST_OWN);
  end

  assign sh_clk       = pt_vec[N_CLT];
  assign sh_init      = pt_vec[N_CLT+1];
  assign sh_oe        = pt_vec[N_CLT+2];
  assign cfg_conflict = route_err | chain_err | (|byp_bad);

  // acc_sum is kept as a named internal for observation
  logic unused_acc;
  assign unused_acc = ^acc_sum;
endmodule

// File: rtl/la_alloc_checker.sv
module la_alloc_checker
  import lalloc_pkg::*;
#(
  parameter int N_IN  = LA_IN,
  parameter int N_MC  = LA_MC,
  parameter int CL_SZ = LA_CL
) (
  input logic [(N_MC*CL_SZ+LA_SH)*2*N_IN-1:0] cfg_and,
  input logic [N_MC*LA_DW-1:0]                cfg_dest,
  input logic [N_MC-1:0]                      cfg_wide,
  input logic [N_MC-1:0]                      cfg_bypass,
  input logic [N_MC-1:0]                      mc_sum,
  input logic                                 cfg_conflict,
  input logic [N_MC*CL_SZ+LA_SH-1:0]          pt_vec,
  input logic [N_MC-1:0]                      cl_or,
  input logic [N_MC-1:0]                      local_sum
);
  localparam int N_PT = N_MC * CL_SZ + LA_SH;
  localparam int FW   = 2 * N_IN;

  always_comb begin
    logic clash;
    logic quiet;
    int   s;
    for (int t = 0; t < N_PT; t++) begin
      clash = 1'b0;
      for (int i = 0; i < N_IN; i++)
        if (cfg_and[t*FW+2*i] && cfg_and[t*FW+2*i+1]) clash = 1'b1;
      if (clash) AST_CLASH_ZERO: assert (!pt_vec[t]) else $error("clash term high"); // R2
    end
    for (int n = 0; n < N_MC; n++) begin
      if (cfg_dest[n*LA_DW +: LA_DW] == DST_OWN && cl_or[n])
        AST_HOME_REACHES: assert (local_sum[n]) else $error("home cluster lost"); // R4
      quiet = 1'b1;
      for (int k = -2; k <= 2; k++) begin
        s = n + k;
        if (s >= 0 && s < N_MC && cl_or[s]) quiet = 1'b0;
      end
      if (quiet) AST_QUIET_SLICE: assert (!local_sum[n]) else $error("sum from nowhere"); // R6
      if (cfg_wide[n]) AST_FWD_SILENT: assert (!mc_sum[n]) else $error("forwarding slice drives"); // R8
      if (cfg_bypass[n] && !cfg_wide[n])
        AST_BYPASS_OWN: assert (mc_sum[n] == cl_or[n]) else $error("bypass mismatch"); // R7
    end
    if (cfg_dest[LA_DW-1:0] == DST_DN1 || cfg_dest[LA_DW-1:0] == DST_DN2 ||
        cfg_dest[(N_MC-1)*LA_DW +: LA_DW] == DST_UP1 || cfg_dest[(N_MC-1)*LA_DW +: LA_DW] == DST_UP2)
      AST_EDGE_CONFLICT: assert (cfg_conflict) else $error("edge steer unflagged"); // R6
    if (cfg_wide[N_MC-1])
      AST_TOP_WIDE_CONFLICT: assert (cfg_conflict) else $error("top forward unflagged"); // R9
  end
endmodule

bind logic_alloc_block la_alloc_checker #(.N_IN(N_IN), .N_MC(N_MC), .CL_SZ(CL_SZ)) u_la_chk (.*);

// File: tb/logic_alloc_block_bench.sv
module logic_alloc_block_bench;
  import lalloc_pkg::*;
  localparam int NI = LA_IN, NM = LA_MC, NC = LA_CL;
  localparam int NPT = NM * NC + LA_SH;
  localparam int FW = 2 * NI;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NI-1:0]       in_sig;
  logic [NPT*FW-1:0]   cfg_and;
  logic [NM*LA_DW-1:0] cfg_dest;
  logic [NM-1:0]       cfg_wide, cfg_bypass, mc_sum;
  logic sh_clk, sh_init, sh_oe, cfg_conflict;

  logic_alloc_block u_logic_alloc_block (
    .in_sig(in_sig), .cfg_and(cfg_and), .cfg_dest(cfg_dest), .cfg_wide(cfg_wide),
    .cfg_bypass(cfg_bypass), .mc_sum(mc_sum), .sh_clk(sh_clk), .sh_init(sh_init),
    .sh_oe(sh_oe), .cfg_conflict(cfg_conflict)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [NM-1:0] exp_sum;
  logic [2:0]    exp_sh;
  logic          exp_conf;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // term value straight from the literal rules (R1, R2)
  function automatic logic ref_term(input int t);
    logic v = 1'b1;
    for (int i = 0; i < NI; i++) begin
      if (cfg_and[t*FW+2*i] == 1'b1 && in_sig[i] == 1'b0) v = 1'b0;
      if (cfg_and[t*FW+2*i+1] == 1'b1 && in_sig[i] == 1'b1) v = 1'b0;
    end
    return v;
  endfunction

  // scatter each cluster to its target, then walk the chains upward
  task automatic ref_eval();
    logic [NM-1:0] cl, loc, acc;
    int tgt, code;
    cl = '0; loc = '0; acc = '0; exp_conf = 1'b0;
    for (int c = 0; c < NM; c++)
      for (int j = 0; j < NC; j++) if (ref_term(c*NC+j)) cl[c] = 1'b1;
    for (int c = 0; c < NM; c++) begin
      code = int'(cfg_dest[c*LA_DW +: LA_DW]);
      tgt = -100;
      case (code)
        0: tgt = c;     1: tgt = c - 1; 2: tgt = c - 2;
        3: tgt = c + 1; 4: tgt = c + 2; default: tgt = -100;
      endcase
      if (tgt != -100) begin
        if (tgt >= 0 && tgt < NM) loc[tgt] = loc[tgt] | cl[c];
        else exp_conf = 1'b1;
      end
      if (cfg_bypass[c] && code != 0) exp_conf = 1'b1;
      if (cfg_wide[c] && c + 4 >= NM) exp_conf = 1'b1;
    end
    for (int n = 0; n < NM; n++) begin
      acc[n] = loc[n];
      if (n >= 4 && cfg_wide[n-4]) acc[n] = acc[n] | acc[n-4];
      if (cfg_wide[n]) exp_sum[n] = 1'b0;
      else if (cfg_bypass[n]) exp_sum[n] = cl[n];
      else exp_sum[n] = acc[n];
    end
    exp_sh = {ref_term(NM*NC+2), ref_term(NM*NC+1), ref_term(NM*NC)};
  endtask

  task automatic clear_cfg();
    cfg_and = '0; cfg_dest = '0; cfg_wide = '0; cfg_bypass = '0;
  endtask

  // make every cluster term 0 except those of cluster keep (a clash on input 0)
  task automatic only_cluster(input int keep);
    for (int t = 0; t < NM*NC; t++)
      if (t / NC != keep) begin
        cfg_and[t*FW] = 1'b1; cfg_and[t*FW+1] = 1'b1;
      end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic rand_cfg();
    int k, i;
    clear_cfg();
    for (int t = 0; t < NPT; t++) begin
      k = int'($urandom % 3) + 1;
      for (int j = 0; j < k; j++) begin
        i = int'($urandom % NI);
        cfg_and[t*FW + 2*i + int'($urandom % 2)] = 1'b1;
      end
    end
    for (int c = 0; c < NM; c++) begin
      if ($urandom % 10 < 6) cfg_dest[c*LA_DW +: LA_DW] = 3'd0;
      else cfg_dest[c*LA_DW +: LA_DW] = 3'($urandom % 8);
      cfg_wide[c]   = ($urandom % 5) == 0;
      cfg_bypass[c] = ($urandom % 7) == 0;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    in_sig = '0;
    clear_cfg();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk);

    // R1 R3: blank fuses give all-ones terms; shared terms come out on their own pins
    clear_cfg(); in_sig = 36'h5_A5A5_A5A5; settle();
    chk("R1 blank sums", 32'(mc_sum), 32'hFFFF);
    chk("R3 shared blank", 32'({sh_oe, sh_init, sh_clk}), 32'h7);
    chk("R1 conflict clear", 32'(cfg_conflict), 32'h0);

    // R1: term 80 = in[3] & ~in[9]
    cfg_and[80*FW + 6] = 1'b1; cfg_and[80*FW + 19] = 1'b1;
    in_sig = '0; in_sig[3] = 1'b1; settle();
    chk("R1 literal true", 32'(sh_clk), 32'h1);
    in_sig[9] = 1'b1; settle();
    chk("R1 literal compl", 32'(sh_clk), 32'h0);

    // R3: shared terms never reach sums
    clear_cfg(); only_cluster(-1); settle();
    chk("R3 shared excluded", 32'(mc_sum), 32'h0);
    chk("R3 shared still high", 32'({sh_oe, sh_init, sh_clk}), 32'h7);

    // R2: clash in cluster 0
    clear_cfg();
    for (int j = 0; j < NC; j++) begin cfg_and[j*FW+14] = 1'b1; cfg_and[j*FW+15] = 1'b1; end
    in_sig = '1; settle();
    chk("R2 clash zero", 32'(mc_sum), 32'hFFFE);

    // R4: cluster 5 to n+2
    clear_cfg(); only_cluster(5); cfg_dest[5*LA_DW +: LA_DW] = 3'd4; settle();
    chk("R4 steer up2", 32'(mc_sum), 32'h0080);
    cfg_dest[5*LA_DW +: LA_DW] = 3'd2; settle();
    chk("R4 steer dn2", 32'(mc_sum), 32'h0008);

    // R5: parked
    cfg_dest[5*LA_DW +: LA_DW] = 3'd6; settle();
    chk("R5 parked sums", 32'(mc_sum), 32'h0);
    chk("R5 parked no conflict", 32'(cfg_conflict), 32'h0);

    // R6: no wrap at either edge
    clear_cfg(); only_cluster(0); cfg_dest[2:0] = 3'd1; settle();
    chk("R6 low edge", 32'({cfg_conflict, mc_sum}), 32'h10000);
    clear_cfg(); only_cluster(15); cfg_dest[15*LA_DW +: LA_DW] = 3'd4; settle();
    chk("R6 high edge", 32'({cfg_conflict, mc_sum}), 32'h10000);

    // R8: chain 0 -> 4 -> 8 -> 12
    clear_cfg(); only_cluster(0); cfg_wide = 16'h0111; settle();
    chk("R8 chain to 12", 32'({cfg_conflict, mc_sum}), 32'h01000);
    cfg_wide = 16'h0011; settle();
    chk("R8 chain to 8", 32'(mc_sum), 32'h0100);

    // R9: forwarding from slice 12 discards
    cfg_wide = 16'h1111; settle();
    chk("R9 top forward", 32'({cfg_conflict, mc_sum}), 32'h10000);

    // R7: bypass drops steered-in cluster 2
    clear_cfg(); only_cluster(2); cfg_dest[2*LA_DW +: LA_DW] = 3'd3; settle();
    chk("R7 no bypass", 32'(mc_sum), 32'h0008);
    cfg_bypass[3] = 1'b1; settle();
    chk("R7 bypass own only", 32'({cfg_conflict, mc_sum}), 32'h00000);

    // R10: bypass with cluster steered away
    clear_cfg(); cfg_bypass[6] = 1'b1; cfg_dest[6*LA_DW +: LA_DW] = 3'd3; settle();
    chk("R10 bypass conflict", 32'(cfg_conflict), 32'h1);

    // R11 plus all: random configurations against the model, outputs
    // compared one half cycle after each change with no clock in the block
    for (int cfgn = 0; cfgn < 40; cfgn++) begin
      rand_cfg();
      for (int v = 0; v < 12; v++) begin
        in_sig = {$urandom, $urandom};
        settle();
        ref_eval();
        chk("R11 R4 R8 random sums", 32'(mc_sum), 32'(exp_sum));
        chk("R3 random shared", 32'({sh_oe, sh_init, sh_clk}), 32'(exp_sh));
        chk("R6 R9 R10 random conflict", 32'(cfg_conflict), 32'(exp_conf));
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule